// File: doc/BRIEF.md
# IR Run-Length Transmitter with Carrier

The block plays out an infrared message that the host supplies as a stream of run-length bytes. Each byte names an interval type (pulse or space) and a length in 10 µs units. Bytes enter through a valid/ready write port into a 16-entry queue. A sequencer drains the queue with no gap between bytes. During pulse intervals it drives a carrier, derived from the system clock, onto one of four IR outputs. The output is held low during spaces and while idle.

The host must tell the block where a message ends. It writes an end mark to the aux control register before, or together with, the final byte. The block then stops after that byte. If the queue runs dry with no end mark, the block stops and latches an underrun, which the host clears by writing a one. The host can mask three interrupt causes: queue low, queue empty and error. The carrier code and the output select can be changed only while no message is playing.

Back-pressure on the write port follows these rules. `wr_ready` is low only while the queue holds 16 bytes. A byte is taken on a clock edge where both `wr_valid` and `wr_ready` are high. While `wr_ready` is low, `wr_valid` and `wr_data` have no effect.

Top module: `irtx_core`

## Requirements
- R1: A byte with bits 6:0 = X lasts exactly (X+1)×(CLK_HZ/100000) clock cycles. Bit 7 = 1 makes it a space and 0 makes it a pulse. Queued bytes play back to back, so `tx_busy` stays high for exactly the sum of their lengths.
- R2: The queue holds 16 bytes. `wr_ready` is low only when it is full, and a write offered while `wr_ready` is low is dropped.
- R3: During a pulse run, the selected output carries a square wave. Its period is round(CLK_HZ/f) cycles and its high time is round(CLK_HZ×7 µs) cycles. Each high phase starts at the first cycle of the period. The phase restarts when a pulse run begins after a space or after idle, and runs on across consecutive pulse bytes. All outputs are low during spaces and while idle.
- R4: The carrier code selects the frequency f. Codes 0, 1 and 2 give 58, 59 and 60 kHz. Code 30 gives 56.9 kHz. Every other code c gives (c+27) kHz. After reset the code is 9 (36 kHz).
- R5: The output select s (0 to 3) routes the carrier to `ir_out[s]` only, and every other output stays low. After reset s is 0.
- R6: A write to the carrier code or to the output select made while `tx_busy` is high is ignored.
- R7: Writing `aux_wdata` bit 2 = 1 arms the end mark, and `aux_stat` bit 2 reads 1 while it is armed. The next byte accepted is the final byte; if a byte is accepted in the same cycle as the arming write, that byte is the final byte. Accepting the final byte disarms the mark. After the final byte, `tx_busy` falls and no underrun is recorded.
- R8: If a byte that is not final ends while the queue is empty, `tx_busy` falls and `aux_stat` bit 6 is set. Writing `aux_wdata` bit 6 = 1 clears it. If a new underrun falls in the same cycle as the clearing write, the bit stays set.
- R9: The interrupt status `irq_stat` is the raw cause vector ANDed with `irq_en`. Bit 1 means busy with 3 or fewer bytes queued, bit 2 means an underrun is latched, and bit 5 means the queue is empty. All other bits are 0. `irq` is the OR of `irq_stat`.
- R10: After reset the block is idle. `wr_ready` = 1, all outputs are low, `aux_stat` = 0, and with `irq_en` = 0, `irq` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock of CLK_HZ |
| rst_n | input | 1 | Active-low reset |
| wr_valid | input | 1 | Run-length byte offered |
| wr_ready | output | 1 | Queue can take a byte |
| wr_data | input | 8 | Run-length byte: bit 7 space, bits 6:0 length code |
| aux_wr | input | 1 | Aux control write strobe |
| aux_wdata | input | 8 | Bit 2 arms end mark, bit 6 clears underrun |
| car_wr | input | 1 | Carrier code write strobe |
| car_code | input | CODE_W | Carrier code |
| sel_wr | input | 1 | Output select write strobe |
| sel_code | input | SW | Output select |
| irq_en | input | 8 | Interrupt enable mask |
| irq_stat | output | 8 | Masked interrupt causes |
| irq | output | 1 | Interrupt request |
| aux_stat | output | 8 | Bit 2 end mark armed, bit 6 underrun |
| tx_busy | output | 1 | A message is playing |
| ir_out | output | NOUT | IR transmit outputs |

## Verification
Two functions can meet in a single cycle.

The first pair is the host's write-one clear of the underrun flag and a new underrun being latched. The bench sends a single-byte message with no end mark, counts the busy cycles, and issues the clearing write on the edge where the byte ends. It then judges that the flag still reads 1, and that a later clear takes effect.

The second pair is arming the end mark and accepting a byte. The bench raises both in one cycle for the last byte of a message. It judges that the message stops cleanly with no underrun and that the mark reads disarmed afterwards.

// File: rtl/irtx_pkg.sv
`timescale 1ns/1ps
package irtx_pkg;
  localparam int LEN_W     = 7;
  localparam int IRQ_LOW   = 1;
  localparam int IRQ_ERR   = 2;
  localparam int IRQ_EMPTY = 5;
  localparam int AUX_EOT   = 2;
  localparam int AUX_UNDR  = 6;
  localparam int RESET_CAR = 9;

  typedef struct packed {
    logic             last;
    logic             space;
    logic [LEN_W-1:0] len;
  } ent_t;

  function automatic int rdiv(input int num, input int den);
    return (num + den / 2) / den;
  endfunction

  function automatic int car_hz(input int code);
    if (code <= 2)
      return 58000 + 1000 * code;
    else if (code == 30)
      return 56900;
    else
      return (code + 27) * 1000;
  endfunction
endpackage

// File: rtl/irtx_fifo.sv
`timescale 1ns/1ps
module irtx_fifo #(
  parameter  int WIDTH = 9,
  parameter  int DEPTH = 16,
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] dout,
  output logic [CW-1:0]    level,
  output logic             full,
  output logic             empty
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wp, rp;
  logic [CW-1:0]    cnt;
  logic             do_push, do_pop;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (cnt == CW'(DEPTH));
  assign empty   = (cnt == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rp];
  assign level   = cnt;

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= bump(wp);
      if (do_pop)  rp <= bump(rp);
      cnt <= cnt + CW'(do_push) - CW'(do_pop);
    end
  end
endmodule

// File: rtl/irtx_player.sv
`timescale 1ns/1ps
module irtx_player
  import irtx_pkg::*;
#(
  parameter  int TICK = 240,
  localparam int TW   = $clog2(TICK + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic head_vld,
  input  ent_t head,
  output logic pop,
  output logic busy,
  output logic space,
  output logic restart,
  output logic underrun
);
  logic             busy_q, space_q, last_q;
  logic [LEN_W-1:0] units_q;
  logic [TW-1:0]    tick_q;
  logic             tick_end, byte_end, take;

  assign tick_end = (tick_q == TW'(TICK - 1));
  assign byte_end = busy_q && tick_end && (units_q == '0);
  assign take     = head_vld && (!busy_q || (byte_end && !last_q));
  assign pop      = take;
  assign restart  = take && !head.space && (!busy_q || space_q);
  assign underrun = byte_end && !last_q && !head_vld;
  assign busy     = busy_q;
  assign space    = space_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      space_q <= 1'b0;
      last_q  <= 1'b0;
      units_q <= '0;
      tick_q  <= '0;
    end else if (take) begin
      busy_q  <= 1'b1;
      space_q <= head.space;
      last_q  <= head.last;
      units_q <= head.len;
      tick_q  <= '0;
    end else if (byte_end) begin
      busy_q  <= 1'b0;
    end else if (busy_q) begin
      if (tick_end) begin
        tick_q  <= '0;
        units_q <= units_q - 1'b1;
      end else begin
        tick_q  <= tick_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/irtx_carrier.sv
`timescale 1ns/1ps
module irtx_carrier
  import irtx_pkg::*;
#(
  parameter  int CLK_HZ  = 24_000_000,
  parameter  int CODE_W  = 5,
  localparam int NCODE   = 1 << CODE_W,
  localparam int PER_MAX = rdiv(CLK_HZ, 30000),
  localparam int PW      = $clog2(PER_MAX + 1),
  localparam int HIGH    = rdiv(CLK_HZ / 1000 * 7, 1000)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic [CODE_W-1:0] code,
  output logic              hi
);
  logic [PW-1:0] per_tab [NCODE];
  logic [PW-1:0] per, ph_q;

  for (genvar g = 0; g < NCODE; g++) begin : g_tab
    assign per_tab[g] = PW'(rdiv(CLK_HZ, car_hz(g)));
  end

  assign per = per_tab[code];
  assign hi  = (ph_q < PW'(HIGH));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                ph_q <= '0;
    else if (restart)          ph_q <= '0;
    else if (ph_q >= per - 1'b1) ph_q <= '0;
    else                       ph_q <= ph_q + 1'b1;
  end
endmodule

// File: rtl/irtx_core.sv
`timescale 1ns/1ps
module irtx_core
  import irtx_pkg::*;
#(
  parameter  int CLK_HZ   = 24_000_000,
  parameter  int DEPTH    = 16,
  parameter  int LOW_MARK = 3,
  parameter  int NOUT     = 4,
  parameter  int CODE_W   = 5,
  localparam int SW       = (NOUT > 1) ? $clog2(NOUT) : 1,
  localparam int TICK     = rdiv(CLK_HZ, 100000),
  localparam int CW       = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [7:0]        wr_data,
  input  logic              aux_wr,
  input  logic [7:0]        aux_wdata,
  input  logic              car_wr,
  input  logic [CODE_W-1:0] car_code,
  input  logic              sel_wr,
  input  logic [SW-1:0]     sel_code,
  input  logic [7:0]        irq_en,
  output logic [7:0]        irq_stat,
  output logic              irq,
  output logic [7:0]        aux_stat,
  output logic              tx_busy,
  output logic [NOUT-1:0]   ir_out
);
  ent_t              push_ent, head;
  logic [CW-1:0]     level;
  logic              full, empty, pop, accept;
  logic              busy, space, restart, undr_evt, car_hi;
  logic              eot_q, eot_set, undr_q;
  logic [SW-1:0]     sel_q;
  logic [CODE_W-1:0] car_q;
  logic [7:0]        raw;
  logic              unused_aux;

  assign unused_aux = ^{aux_wdata[7], aux_wdata[5:3], aux_wdata[1:0]};

  assign wr_ready = !full;
  assign accept   = wr_valid && !full;
  assign eot_set  = aux_wr && aux_wdata[AUX_EOT];
  assign push_ent = '{last: eot_q || eot_set, space: wr_data[7], len: wr_data[LEN_W-1:0]};

  irtx_fifo #(.WIDTH($bits(ent_t)), .DEPTH(DEPTH)) u_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (accept),
    .din   (push_ent),
    .pop   (pop),
    .dout  (head),
    .level (level),
    .full  (full),
    .empty (empty)
  );

  irtx_player #(.TICK(TICK)) u_player (
    .clk      (clk),
    .rst_n    (rst_n),
    .head_vld (!empty),
    .head     (head),
    .pop      (pop),
    .busy     (busy),
    .space    (space),
    .restart  (restart),
    .underrun (undr_evt)
  );

  irtx_carrier #(.CLK_HZ(CLK_HZ), .CODE_W(CODE_W)) u_carrier (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (restart),
    .code    (car_q),
    .hi      (car_hi)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eot_q  <= 1'b0;
      undr_q <= 1'b0;
      sel_q  <= '0;
      car_q  <= CODE_W'(RESET_CAR);
    end else begin
      if (accept)       eot_q <= 1'b0;
      else if (eot_set) eot_q <= 1'b1;
      if (undr_evt)                             undr_q <= 1'b1;
      else if (aux_wr && aux_wdata[AUX_UNDR])   undr_q <= 1'b0;
      if (sel_wr && !busy) sel_q <= sel_code;
      if (car_wr && !busy) car_q <= car_code;
    end
  end

  always_comb begin
    raw            = '0;
    raw[IRQ_LOW]   = busy && (level <= CW'(LOW_MARK));
    raw[IRQ_ERR]   = undr_q;
    raw[IRQ_EMPTY] = empty;
    aux_stat           = '0;
    aux_stat[AUX_EOT]  = eot_q;
    aux_stat[AUX_UNDR] = undr_q;
  end

  assign irq_stat = raw & irq_en;
  assign irq      = |irq_stat;
  assign tx_busy  = busy;

  for (genvar i = 0; i < NOUT; i++) begin : g_out
    assign ir_out[i] = busy && !space && car_hi && (sel_q == SW'(i));
  end
endmodule

// File: rtl/irtx_chk.sv
`timescale 1ns/1ps
module irtx_chk #(
  parameter int NOUT   = 4,
  parameter int SW     = 2,
  parameter int CODE_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tx_busy,
  input logic              wr_ready,
  input logic [NOUT-1:0]   ir_out,
  input logic              undr,
  input logic              aux_clr,
  input logic [SW-1:0]     sel_q,
  input logic [CODE_W-1:0] car_q
);
  AST_ONE_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ir_out)); // R5
  AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_busy |-> (ir_out == '0)); // R3
  AST_FULL_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ready |-> tx_busy); // R2
  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    tx_busy |=> ($stable(sel_q) && $stable(car_q))); // R6
  AST_UNDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (undr && !aux_clr) |=> undr); // R8
  AST_UNDR_FELL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(undr) |-> $past(aux_clr)); // R8
  AST_UNDR_ROSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(undr) |-> $fell(tx_busy)); // R8
endmodule

bind irtx_core irtx_chk #(.NOUT(NOUT), .SW(SW), .CODE_W(CODE_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .tx_busy  (tx_busy),
  .wr_ready (wr_ready),
  .ir_out   (ir_out),
  .undr     (aux_stat[irtx_pkg::AUX_UNDR]),
  .aux_clr  (aux_wr && aux_wdata[irtx_pkg::AUX_UNDR]),
  .sel_q    (sel_q),
  .car_q    (car_q)
);

// File: tb/tb_irtx_core.sv
`timescale 1ns/1ps
module tb_irtx_core;
  localparam int CLK_HZ = 2_400_000;
  localparam int UNIT   = CLK_HZ / 100000;
  localparam int HIGHC  = (CLK_HZ / 1000 * 7 + 500) / 1000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_valid = 1'b0, wr_ready;
  logic [7:0] wr_data = '0;
  logic       aux_wr = 1'b0;
  logic [7:0] aux_wdata = '0;
  logic       car_wr = 1'b0;
  logic [4:0] car_code = '0;
  logic       sel_wr = 1'b0;
  logic [1:0] sel_code = '0;
  logic [7:0] irq_en = '0, irq_stat, aux_stat;
  logic       irq, tx_busy;
  logic [3:0] ir_out;

  always #2.5 clk = ~clk;

  irtx_core #(.CLK_HZ(CLK_HZ)) dut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_data(wr_data), .aux_wr(aux_wr), .aux_wdata(aux_wdata),
    .car_wr(car_wr), .car_code(car_code), .sel_wr(sel_wr), .sel_code(sel_code),
    .irq_en(irq_en), .irq_stat(irq_stat), .irq(irq), .aux_stat(aux_stat),
    .tx_busy(tx_busy), .ir_out(ir_out)
  );

  int n_run = 0, n_fail = 0;
  int cur_code = 9, cur_idx = 0;

  typedef struct {int len; int hi; int edges; int idx; bit undr; string req;} exp_t;
  exp_t       sb[$];
  logic [7:0] msg[$];

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int per_of(input int code);
    int hz;
    if (code == 30)     hz = 56900;
    else if (code < 3)  hz = 58000 + code * 1000;
    else                hz = 1000 * (27 + code);
    return (CLK_HZ + hz / 2) / hz;
  endfunction

  task automatic expect_msg(input bit undr, input string req);
    exp_t e;
    int p, run, l;
    p = per_of(cur_code);
    e.len = 0; e.hi = 0; e.edges = 0; e.idx = cur_idx; e.undr = undr; e.req = req;
    run = 0;
    for (int i = 0; i <= msg.size(); i++) begin
      if (i < msg.size()) begin
        l = (int'(msg[i][6:0]) + 1) * UNIT;
        e.len += l;
      end
      if (i < msg.size() && !msg[i][7]) run += l;
      else begin
        e.hi    += (run / p) * HIGHC + ((run % p) < HIGHC ? run % p : HIGHC);
        e.edges += (run + p - 1) / p;
        run = 0;
      end
    end
    sb.push_back(e);
  endtask

  // mode 0: no end mark, 1: mark armed one cycle earlier, 2: mark with last byte
  task automatic play(input int mode, input string req);
    expect_msg(mode == 0, req);
    for (int i = 0; i < msg.size(); i++) begin
      if (i == msg.size() - 1 && mode == 1) begin
        @(negedge clk); wr_valid = 1'b0; aux_wr = 1'b1; aux_wdata = 8'h04;
        @(negedge clk); aux_wr = 1'b0; aux_wdata = 8'h00;
        chk("R7", "mark armed", int'(aux_stat[2]), 1);
      end else begin
        @(negedge clk);
      end
      wr_valid = 1'b0;
      while (!wr_ready) @(negedge clk);
      wr_valid = 1'b1; wr_data = msg[i];
      if (i == msg.size() - 1 && mode == 2) begin aux_wr = 1'b1; aux_wdata = 8'h04; end
    end
    @(negedge clk); wr_valid = 1'b0; aux_wr = 1'b0; aux_wdata = 8'h00;
    if (mode != 0) chk("R7", "mark disarmed", int'(aux_stat[2]), 0);
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (tx_busy || sb.size() != 0) @(negedge clk);
  endtask

  task automatic clear_undr();
    @(negedge clk); aux_wr = 1'b1; aux_wdata = 8'h40;
    @(negedge clk); aux_wr = 1'b0; aux_wdata = 8'h00;
  endtask

  task automatic set_cfg(input int code, input int idx);
    @(negedge clk); car_wr = 1'b1; car_code = 5'(code); sel_wr = 1'b1; sel_code = 2'(idx);
    @(negedge clk); car_wr = 1'b0; sel_wr = 1'b0;
  endtask

  // monitor: measures each busy run and compares against the scoreboard
  initial begin
    int len; int hi[4]; int ed[4]; bit pv[4]; bit act; int oth;
    exp_t e;
    act = 0; len = 0; oth = 0;
    for (int k = 0; k < 4; k++) begin hi[k] = 0; ed[k] = 0; pv[k] = 0; end
    forever begin
      @(negedge clk);
      if (tx_busy) begin
        if (!act) begin
          act = 1; len = 0;
          for (int k = 0; k < 4; k++) begin hi[k] = 0; ed[k] = 0; pv[k] = 0; end
        end
        len++;
        for (int k = 0; k < 4; k++) begin
          if (ir_out[k]) begin hi[k]++; if (!pv[k]) ed[k]++; end
          pv[k] = ir_out[k];
        end
      end else if (act) begin
        act = 0;
        if (sb.size() == 0) chk("R1", "unexpected message", 1, 0);
        else begin
          e = sb.pop_front();
          chk("R1", "busy length", len, e.len);
          chk(e.req, "carrier high cycles", hi[e.idx], e.hi);
          chk(e.req, "carrier edges", ed[e.idx], e.edges);
          oth = 0;
          for (int k = 0; k < 4; k++) if (k != e.idx) oth += hi[k];
          chk("R5", "activity on unselected outputs", oth, 0);
          chk(e.undr ? "R8" : "R7", "underrun at end", int'(aux_stat[6]), int'(e.undr));
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL R1 watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int acc;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10", "wr_ready", int'(wr_ready), 1);
    chk("R10", "tx_busy", int'(tx_busy), 0);
    chk("R10", "ir_out", int'(ir_out), 0);
    chk("R10", "aux_stat", int'(aux_stat), 0);
    chk("R10", "irq", int'(irq), 0);
    irq_en = 8'h26;
    @(negedge clk);
    chk("R9", "idle irq_stat", int'(irq_stat), 8'h20);
    chk("R9", "idle irq", int'(irq), 1);

    // reset carrier (36 kHz) on output 1, alternating intervals
    msg = '{8'h05, 8'h83, 8'h0A, 8'h81};
    play(1, "R3");
    chk("R9", "low level while draining", int'(irq_stat[1]), 1);
    chk("R9", "empty flag while queued", int'(irq_stat[5]), 0);
    wait_idle();

    // consecutive pulse bytes keep carrier phase; mark with last byte
    msg = '{8'h02, 8'h04, 8'h81, 8'h03};
    play(2, "R3");
    wait_idle();

    // 58 kHz on output 3
    set_cfg(0, 2); cur_code = 0; cur_idx = 2;
    msg = '{8'h10, 8'h85, 8'h20, 8'h80};
    play(1, "R4");
    @(negedge clk);
    chk("R6", "busy during config write", int'(tx_busy), 1);
    car_wr = 1'b1; car_code = 5'd30; sel_wr = 1'b1; sel_code = 2'd1;
    @(negedge clk); car_wr = 1'b0; sel_wr = 1'b0;
    wait_idle();
    msg = '{8'h07, 8'h87, 8'h09};
    play(1, "R6");
    wait_idle();

    // 56.9 kHz, then 30 kHz on output 4
    set_cfg(30, 2); cur_code = 30;
    msg = '{8'h0C, 8'h82, 8'h06};
    play(2, "R4");
    wait_idle();
    set_cfg(3, 3); cur_code = 3; cur_idx = 3;
    msg = '{8'h0B, 8'h84, 8'h05};
    play(1, "R5");
    wait_idle();

    // underrun without end mark
    irq_en = 8'h04;
    msg = '{8'h08, 8'h88, 8'h08};
    play(0, "R8");
    wait_idle();
    chk("R8", "underrun latched", int'(aux_stat[6]), 1);
    chk("R9", "error cause", int'(irq_stat[2]), 1);
    chk("R9", "irq from error", int'(irq), 1);
    clear_undr();
    chk("R8", "underrun cleared", int'(aux_stat[6]), 0);
    chk("R9", "irq after clear", int'(irq), 0);

    // clear write in the very cycle a new underrun is set
    msg = '{8'h00};
    expect_msg(1, "R8");
    @(negedge clk);
    wr_valid = 1'b1; wr_data = 8'h00;
    @(negedge clk); wr_valid = 1'b0;
    while (!tx_busy) @(negedge clk);
    repeat (23) @(negedge clk);
    aux_wr = 1'b1; aux_wdata = 8'h40;
    @(negedge clk); aux_wr = 1'b0; aux_wdata = 8'h00;
    chk("R8", "set wins over clear", int'(aux_stat[6]), 1);
    chk("R1", "single byte ended", int'(tx_busy), 0);
    wait_idle();
    clear_undr();
    chk("R8", "later clear", int'(aux_stat[6]), 0);

    // queue fill to full, writes dropped while not ready
    irq_en = 8'h22;
    msg.delete();
    for (int i = 0; i < 17; i++) msg.push_back((i % 2) ? 8'h94 : 8'h14);
    expect_msg(1, "R2");
    acc = 0;
    @(negedge clk);
    while (wr_ready && acc < 40) begin
      wr_valid = 1'b1; wr_data = (acc % 2) ? 8'h94 : 8'h14;
      acc++;
      @(negedge clk);
    end
    wr_data = 8'h14;
    repeat (3) @(negedge clk);
    chk("R2", "bytes accepted until full", acc, 17);
    chk("R2", "ready while full", int'(wr_ready), 0);
    chk("R9", "low cause while full", int'(irq_stat[1]), 0);
    wr_valid = 1'b0;
    wait_idle();
    chk("R9", "empty cause at end", int'(irq_stat[5]), 1);
    clear_undr();
    chk("R7", "mark idle at end", int'(aux_stat[2]), 0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule